// File: doc/BRIEF.md
# Minifloat to Float32 Expander

The block widens one packed 4-bit or 8-bit minifloat code into a 32-bit IEEE binary32 word. The format is fixed per instance by parameters: the exponent width, the mantissa width, the exponent bias, and three capability options. These options say whether the format has an infinity, whether it has a NaN, and whether its only NaN is the code with just the sign bit set. A fourth option says whether the format keeps a negative zero. Every minifloat value can be written exactly in binary32, so the conversion never rounds.

A code arrives with a valid strobe. The result appears on the output one clock later, together with a registered valid. Normal codes are rebiased. Subnormal codes pass through a leading-one detector and leave as exact normalized binary32 values, with no floating-point multiplier. Zero, infinity and NaN are mapped by a fixed priority cascade.

Top module: `mfp_expand`

## Requirements
- R1: A code with nonzero exponent field e and mantissa m that is neither NaN nor infinity produces sign, binary32 exponent e + 127 − BIAS, and fraction m placed in the top MAN_W fraction bits, with the lower bits zero.
- R2: A code with zero exponent and nonzero mantissa m produces the exact normalized binary32 value of m × 2^(1 − BIAS − MAN_W), carrying the code's sign. It never produces a binary32 zero or subnormal.
- R3: In a format with infinity, the all-ones exponent with zero mantissa gives a signed infinity (0x7F800000 with the sign in bit 31). The all-ones exponent with nonzero mantissa gives NaN.
- R4: In a format with NaN but no infinity and no sign-only NaN, NaN is exactly the code whose exponent and mantissa bits are all ones, for either sign. Every other code with the all-ones exponent is a finite normal. A format without NaN never yields NaN, so its all-ones code is its largest finite value.
- R5: Every NaN result is 0x7FC00000, whatever the input sign.
- R6: A code with zero exponent and zero mantissa that is not a NaN gives a binary32 zero. Bit 31 equals the code's sign when HAS_NEG_ZERO is set; otherwise the result is +0.
- R7: In a sign-only-NaN format, the code with only the sign bit set gives 0x7FC00000, not a zero. NaN wins over zero in the priority order (normal < subnormal < zero < infinity < NaN).
- R8: out_valid is in_valid delayed by one clock. out_word changes only in the cycle after an accepted code and holds its value otherwise.
- R9: While rst_n is low, out_valid and out_word are 0.
- R10: For every code that is not a NaN and not a negative zero in a format without negative zero, narrowing the result back to the same format returns the original code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: in_code is to be converted |
| in_code | input | 1+EXP_W+MAN_W | Packed minifloat code: sign in the top bit, then exponent, then mantissa |
| out_valid | output | 1 | Registered strobe for out_word |
| out_word | output | 32 | binary32 result |

## Verification
Five formats are swept over every code: an infinity-carrying 5/2 split, two sign-only-NaN formats, a saturating 4/3 format and a 2/1 format without NaN. The sweep targets the subnormal codes with the leading one at each position. A wrong shift or exponent offset there gives a value off by a power of two, or a stale fraction bit. It also targets the sign-only code. A cascade with zero above NaN would turn that code into +0 or −0. The all-ones codes are probed in each family: an IEEE-style decoder applied to the saturating format would report NaN for its largest finite values. Finally, each result is narrowed back to its code, so a wrong rebias shows up even where the expected word is computed the same way by mistake.

// File: rtl/mfp_pkg.sv
package mfp_pkg;

   localparam int          F32_BIAS     = 127;
   localparam int          F32_FRAC_W   = 23;
   localparam logic [31:0] F32_QNAN     = 32'h7FC0_0000;
   localparam logic [30:0] F32_INF_MAG  = 31'h7F80_0000;

   // class flags of one minifloat code, several may be set at once;
   // the select stage resolves them by priority
   typedef struct packed {
      logic is_nan;
      logic is_inf;
      logic is_zero;
      logic is_sub;
   } mfp_flags_t;

endpackage

// File: rtl/mfp_decode.sv
module mfp_decode
   import mfp_pkg::*;
#(
   parameter int EXP_W         = 4,
   parameter int MAN_W         = 3,
   parameter bit HAS_INF       = 1'b0,
   parameter bit HAS_NAN       = 1'b1,
   parameter bit NAN_SIGN_ONLY = 1'b0,
   localparam int CODE_W       = 1 + EXP_W + MAN_W
) (
   input  logic [CODE_W-1:0] code,
   output logic              sign,
   output logic [EXP_W-1:0]  exp_f,
   output logic [MAN_W-1:0]  man_f,
   output mfp_flags_t        flags
);

   logic exp_zero;
   logic man_zero;

   assign sign     = code[CODE_W-1];
   assign exp_f    = code[CODE_W-2:MAN_W];
   assign man_f    = code[MAN_W-1:0];
   assign exp_zero = (exp_f == '0);
   assign man_zero = (man_f == '0);

   assign flags.is_zero = exp_zero & man_zero;
   assign flags.is_sub  = exp_zero & ~man_zero;

   // NaN detection: one variant per encoding family
   if (!HAS_NAN) begin : g_nan_none
      assign flags.is_nan = 1'b0;
   end else if (NAN_SIGN_ONLY) begin : g_nan_sign
      assign flags.is_nan = (code == {1'b1, {(CODE_W-1){1'b0}}});
   end else if (HAS_INF) begin : g_nan_ieee
      assign flags.is_nan = (exp_f == '1) & ~man_zero;
   end else begin : g_nan_ones
      assign flags.is_nan = (code[CODE_W-2:0] == '1);
   end

   if (HAS_INF) begin : g_inf
      assign flags.is_inf = (exp_f == '1) & man_zero;
   end else begin : g_no_inf
      assign flags.is_inf = 1'b0;
   end

endmodule

// File: rtl/mfp_subnorm.sv
module mfp_subnorm
   import mfp_pkg::*;
#(
   parameter int MAN_W = 3,
   parameter int BIAS  = 7,
   localparam int POS_W    = (MAN_W > 1) ? $clog2(MAN_W) : 1,
   localparam int SUB_BASE = F32_BIAS + 1 - BIAS - MAN_W
) (
   input  logic [MAN_W-1:0]      man_f,
   output logic [7:0]            exp32,
   output logic [F32_FRAC_W-1:0] frac32
);

   logic [POS_W-1:0] lead;
   logic [POS_W:0]   shamt;
   logic [MAN_W-1:0] frac_n;

   // leading-one detect: the highest set bit wins
   always_comb begin
      lead = '0;
      for (int i = 0; i < MAN_W; i++) begin
         if (man_f[i]) lead = POS_W'(i);
      end
   end

   // move the leading one just past the top so it becomes implicit
   assign shamt  = (POS_W+1)'(MAN_W) - {1'b0, lead};
   assign frac_n = man_f << shamt;
   assign exp32  = 8'(SUB_BASE + int'(lead));
   assign frac32 = {frac_n, {(F32_FRAC_W-MAN_W){1'b0}}};

endmodule

// File: rtl/mfp_select.sv
module mfp_select
   import mfp_pkg::*;
#(
   parameter bit HAS_NEG_ZERO = 1'b1
) (
   input  logic       sign,
   input  mfp_flags_t flags,
   input  logic [30:0] norm_mag,
   input  logic [30:0] sub_mag,
   output logic [31:0] word
);

   logic [31:0] zero_word;

   if (HAS_NEG_ZERO) begin : g_signed_zero
      assign zero_word = {sign, 31'd0};
   end else begin : g_pos_zero
      assign zero_word = 32'd0;
   end

   // lowest priority first, each later step overrides
   always_comb begin
      word = {sign, norm_mag};
      if (flags.is_sub)  word = {sign, sub_mag};
      if (flags.is_zero) word = zero_word;
      if (flags.is_inf)  word = {sign, F32_INF_MAG};
      if (flags.is_nan)  word = F32_QNAN;
   end

endmodule

// File: rtl/mfp_expand.sv
module mfp_expand
   import mfp_pkg::*;
#(
   parameter int EXP_W         = 4,
   parameter int MAN_W         = 3,
   parameter int BIAS          = 7,
   parameter bit HAS_INF       = 1'b0,
   parameter bit HAS_NAN       = 1'b1,
   parameter bit NAN_SIGN_ONLY = 1'b0,
   parameter bit HAS_NEG_ZERO  = 1'b1,
   localparam int CODE_W       = 1 + EXP_W + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   output logic [31:0]       out_word
);

   localparam int EXP_MAX  = (1 << EXP_W) - 1;
   localparam int REBIAS   = F32_BIAS - BIAS;

   // elaboration-time parameter checks
   if (CODE_W != 4 && CODE_W != 8) begin : g_bad_width
      $error("mfp_expand: code width must be 4 or 8");
   end
   if (MAN_W < 1 || MAN_W > 7 || EXP_W < 1) begin : g_bad_split
      $error("mfp_expand: unsupported exponent/mantissa split");
   end
   if (NAN_SIGN_ONLY && (!HAS_NAN || HAS_INF || HAS_NEG_ZERO)) begin : g_bad_caps
      $error("mfp_expand: sign-only NaN excludes infinity and negative zero");
   end
   if (REBIAS + 1 - MAN_W < 1 || REBIAS + EXP_MAX > 254) begin : g_bad_bias
      $error("mfp_expand: bias puts results outside binary32 normal range");
   end

   logic             sign;
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   mfp_flags_t       flags;
   logic [7:0]       sub_exp;
   logic [F32_FRAC_W-1:0] sub_frac;
   logic [7:0]       norm_exp;
   logic [30:0]      norm_mag;
   logic [31:0]      word_d;

   mfp_decode #(
      .EXP_W         (EXP_W),
      .MAN_W         (MAN_W),
      .HAS_INF       (HAS_INF),
      .HAS_NAN       (HAS_NAN),
      .NAN_SIGN_ONLY (NAN_SIGN_ONLY)
   ) u_decode (
      .code  (in_code),
      .sign  (sign),
      .exp_f (exp_f),
      .man_f (man_f),
      .flags (flags)
   );

   mfp_subnorm #(
      .MAN_W (MAN_W),
      .BIAS  (BIAS)
   ) u_subnorm (
      .man_f  (man_f),
      .exp32  (sub_exp),
      .frac32 (sub_frac)
   );

   // normal path: rebias the exponent, left-align the mantissa
   assign norm_exp = 8'(int'(exp_f) + REBIAS);
   assign norm_mag = {norm_exp, man_f, {(F32_FRAC_W-MAN_W){1'b0}}};

   mfp_select #(
      .HAS_NEG_ZERO (HAS_NEG_ZERO)
   ) u_select (
      .sign     (sign),
      .flags    (flags),
      .norm_mag (norm_mag),
      .sub_mag  ({sub_exp, sub_frac}),
      .word     (word_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_word <= word_d;
      end
   end

endmodule

// File: rtl/mfp_expand_chk.sv
module mfp_expand_chk #(
   parameter int EXP_W         = 4,
   parameter int MAN_W         = 3,
   parameter bit HAS_NAN       = 1'b1,
   parameter bit NAN_SIGN_ONLY = 1'b0,
   parameter bit HAS_NEG_ZERO  = 1'b1,
   localparam int CODE_W       = 1 + EXP_W + MAN_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [CODE_W-1:0] in_code,
   input logic              out_valid,
   input logic [31:0]       out_word
);

   logic sign_only_code;
   logic zero_mag;
   logic sub_code;

   assign sign_only_code = NAN_SIGN_ONLY && (in_code == {1'b1, {(CODE_W-1){1'b0}}});
   assign zero_mag       = (in_code[CODE_W-2:0] == '0);
   assign sub_code       = (in_code[CODE_W-2:MAN_W] == '0) && !zero_mag;

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);  // R8
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);  // R8
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word));  // R8
   AST_SIGN_ONLY_NAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sign_only_code) |=> out_word == 32'h7FC0_0000);  // R7
   AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && zero_mag && !sign_only_code) |=>
         out_word == {HAS_NEG_ZERO && $past(in_code[CODE_W-1]), 31'd0});  // R6
   AST_SUB_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sub_code) |=> (out_word[30:23] != 8'd0 && out_word[30:23] != 8'hFF));  // R2
   AST_NO_NAN_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !HAS_NAN) |=> out_word[30:23] != 8'hFF);  // R4

endmodule

bind mfp_expand mfp_expand_chk #(
   .EXP_W         (EXP_W),
   .MAN_W         (MAN_W),
   .HAS_NAN       (HAS_NAN),
   .NAN_SIGN_ONLY (NAN_SIGN_ONLY),
   .HAS_NEG_ZERO  (HAS_NEG_ZERO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_code   (in_code),
   .out_valid (out_valid),
   .out_word  (out_word)
);

// File: tb/tb_mfp_expand.sv
module tb_mfp_expand;

   localparam real HALF_NS = 2.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  code = 8'd0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   logic        v_a, v_b, v_c, v_d, v_e;
   logic [31:0] w_a, w_b, w_c, w_d, w_e;

   always #(HALF_NS) clk = ~clk;

   // saturating 4/3 split with all-ones NaN and signed zero (default)
   mfp_expand dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(code),
      .out_valid(v_a), .out_word(w_a));
   mfp_expand #(.EXP_W(5), .MAN_W(2), .BIAS(15), .HAS_INF(1'b1), .HAS_NAN(1'b1),
                .NAN_SIGN_ONLY(1'b0), .HAS_NEG_ZERO(1'b1)) dut_e5m2_ieee (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(code),
      .out_valid(v_b), .out_word(w_b));
   mfp_expand #(.EXP_W(4), .MAN_W(3), .BIAS(8), .HAS_INF(1'b0), .HAS_NAN(1'b1),
                .NAN_SIGN_ONLY(1'b1), .HAS_NEG_ZERO(1'b0)) dut_e4m3_sgn (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(code),
      .out_valid(v_c), .out_word(w_c));
   mfp_expand #(.EXP_W(5), .MAN_W(2), .BIAS(16), .HAS_INF(1'b0), .HAS_NAN(1'b1),
                .NAN_SIGN_ONLY(1'b1), .HAS_NEG_ZERO(1'b0)) dut_e5m2_sgn (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(code),
      .out_valid(v_d), .out_word(w_d));
   mfp_expand #(.EXP_W(2), .MAN_W(1), .BIAS(1), .HAS_INF(1'b0), .HAS_NAN(1'b0),
                .NAN_SIGN_ONLY(1'b0), .HAS_NEG_ZERO(1'b0)) dut_e2m1_nonan (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(code[3:0]),
      .out_valid(v_e), .out_word(w_e));

   function automatic real pow2(int k);
      real r = 1.0;
      if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
      else        for (int i = 0; i < -k; i++) r = r * 0.5;
      return r;
   endfunction

   function automatic bit is_nan_code(int ew, int mw, bit hi, bit hn, bit so, int c);
      int e = (c >> mw) & ((1 << ew) - 1);
      int m = c & ((1 << mw) - 1);
      int mag = c & ((1 << (ew + mw)) - 1);
      if (!hn) return 1'b0;
      if (so)  return c == (1 << (ew + mw));
      if (hi)  return (e == (1 << ew) - 1) && (m != 0);
      return mag == (1 << (ew + mw)) - 1;
   endfunction

   // expected word from the real value of the code
   function automatic logic [31:0] ref_expand(int ew, int mw, int bias, bit hi, bit hn,
                                               bit so, bit nz, int c);
      int  e = (c >> mw) & ((1 << ew) - 1);
      int  m = c & ((1 << mw) - 1);
      logic s = c[ew + mw];
      real v;
      logic [63:0] b;
      int  e32;
      if (is_nan_code(ew, mw, hi, hn, so, c)) return 32'h7FC0_0000;
      if (hi && e == (1 << ew) - 1) return {s, 31'h7F80_0000};
      if (e == 0 && m == 0) return {s & nz, 31'd0};
      if (e == 0) v = real'(m) * pow2(1 - bias - mw);
      else        v = real'((1 << mw) + m) * pow2(e - bias - mw);
      b = $realtobits(v);
      e32 = int'(b[62:52]) - 1023 + 127;
      return {s, e32[7:0], b[51:29]};
   endfunction

   // narrow an exact binary32 value back to the minifloat code
   function automatic int ref_narrow(int ew, int mw, int bias, logic [31:0] w);
      int s = int'(w[31]) << (ew + mw);
      int e32 = int'(w[30:23]);
      int f = int'(w[22:0]);
      int ue;
      if (e32 == 0)   return s;
      if (e32 == 255) return s | (((1 << ew) - 1) << mw);
      ue = e32 - 127;
      if (ue >= 1 - bias) return s | ((ue + bias) << mw) | (f >> (23 - mw));
      return s | ((f | (1 << 23)) >> (23 - mw + (1 - bias - ue)));
   endfunction

   task automatic check_fmt(string fmt, int ew, int mw, int bias, bit hi, bit hn, bit so,
                            bit nz, int c, logic vld, logic [31:0] got);
      logic [31:0] expv = ref_expand(ew, mw, bias, hi, hn, so, nz, c);
      int  e = (c >> mw) & ((1 << ew) - 1);
      int  m = c & ((1 << mw) - 1);
      bit  nan = is_nan_code(ew, mw, hi, hn, so, c);
      string tag;
      int  back;
      if (nan && so)                      tag = "R7";
      else if (nan)                       tag = "R4/R5";
      else if (hi && e == (1 << ew) - 1)  tag = "R3";
      else if (e == 0 && m == 0)          tag = "R6";
      else if (e == 0)                    tag = "R2";
      else if (e == (1 << ew) - 1)        tag = "R4/R1";
      else                                tag = "R1";
      n_chk++;
      if (vld !== 1'b1) begin
         n_bad++;
         $display("FAIL R8 %s code=%02h out_valid got=%b exp=1", fmt, c, vld);
      end
      n_chk++;
      if (got !== expv) begin
         n_bad++;
         $display("FAIL %s %s code=%02h got=%08h exp=%08h", tag, fmt, c, got, expv);
      end
      if (!nan && !(e == 0 && m == 0 && !nz && c[ew + mw])) begin
         back = ref_narrow(ew, mw, bias, got);
         n_chk++;
         if (back != c) begin
            n_bad++;
            $display("FAIL R10 %s round trip got=%02h exp=%02h", fmt, back, c);
         end
      end
   endtask

   initial begin : watchdog
      #(HALF_NS * 2.0 * 200000.0);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired got=hung exp=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] held;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R9: reset state
      n_chk++;
      if (v_a !== 1'b0 || w_a !== 32'd0) begin
         n_bad++;
         $display("FAIL R9 reset got=%b/%08h exp=0/00000000", v_a, w_a);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < 256; c++) begin
         code = 8'(c);
         in_valid = 1'b1;
         @(negedge clk);
         check_fmt("e4m3_sat",  4, 3, 7,  1'b0, 1'b1, 1'b0, 1'b1, c, v_a, w_a);
         check_fmt("e5m2_ieee", 5, 2, 15, 1'b1, 1'b1, 1'b0, 1'b1, c, v_b, w_b);
         check_fmt("e4m3_sgn",  4, 3, 8,  1'b0, 1'b1, 1'b1, 1'b0, c, v_c, w_c);
         check_fmt("e5m2_sgn",  5, 2, 16, 1'b0, 1'b1, 1'b1, 1'b0, c, v_d, w_d);
         if (c < 16)
            check_fmt("e2m1_nonan", 2, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0, c, v_e, w_e);
      end
      // R8: no strobe, new code must not reach the output
      held = w_a;
      in_valid = 1'b0;
      code = 8'h38;
      repeat (2) @(negedge clk);
      n_chk++;
      if (v_a !== 1'b0 || w_a !== held) begin
         n_bad++;
         $display("FAIL R8 hold got=%b/%08h exp=0/%08h", v_a, w_a, held);
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule